// File: doc/BRIEF.md
# Port statistics snapshot unit

This block keeps a set of live traffic counters for each of a small number of switch ports and lets a host read them through a narrow register interface. Each port has several 32-bit event counters, each bumped by a one-cycle pulse, and one 64-bit byte counter that adds a per-cycle byte amount. The host never reads live counters directly. It first writes a capture command naming a port, which copies every counter of that port into a single frozen bank in one clock edge. It then issues fetch commands, one per counter index, and each fetch places one 32-bit word of the frozen copy in two 16-bit data registers.

Every accepted command raises a busy flag in the command register for a fixed, parameterised number of cycles. The host polls that flag, at most ten times, before it issues the next command or reads the data registers. Commands written while busy is set are dropped. The live counters keep running throughout, so all values fetched after one capture come from the same instant.

Top module: `port_stats_snap`

## Requirements
- R1: After reset the command register (address 0x1D), the upper data register (0x1E) and the lower data register (0x1F) all read as zero.
- R2: Event counter e of port p increments by one, wrapping at 2^32, on every cycle in which its input bit evt_inc[p*NUM_EVT+e] is high. A later fetch returns it at index e.
- R3: The 64-bit byte counter of port p adds oct_add[p*32 +: 32] on every cycle. A fetch returns its low word at index NUM_EVT and its high word at index NUM_EVT+1.
- R4: Writing 0xDC00 OR p to address 0x1D (bits 15:10 = 110111, bits 9:0 = port) with p < NUM_PORTS, while not busy, copies all counters of port p into the capture bank. The copy holds the values from before that edge, so increments presented in the same cycle are left out.
- R5: Writing 0xCC00 OR n to address 0x1D (bits 15:10 = 110011, bits 9:0 = index) while not busy loads captured word n. Its bits 31:16 then read at 0x1E and its bits 15:0 at 0x1F.
- R6: Captured values do not change as live counters advance. Only a new accepted capture replaces them.
- R7: Bit 15 of address 0x1D is set from the clock edge that accepts a command for exactly BUSY_CYCLES cycles, and then clears. The other bits read zero.
- R8: A command written while busy is ignored. It changes neither the capture bank nor the data registers and does not extend busy.
- R9: A fetch of an index greater than NUM_EVT+1 returns zero in both data registers.
- R10: A capture naming a port at or above NUM_PORTS, or a write to 0x1D whose bits 15:10 match neither command, is ignored and does not set busy.
- R11: Writes to 0x1E or 0x1F have no effect, and reads of any address other than 0x1D, 0x1E and 0x1F return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_inc | input | NUM_PORTS*NUM_EVT | One-cycle increment pulses, bit p*NUM_EVT+e for event counter e of port p |
| oct_add | input | NUM_PORTS*32 | Per-port byte amount added each cycle to the 64-bit byte counter |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 5 | Register read address |
| reg_rdata | output | 16 | Register read data, combinational from reg_raddr |

## Verification
Random event pulses and random byte amounts, including all-ones amounts that carry into the high word, run on every port while captures and full index sweeps are issued. Each sweep is compared with the counter values as they stood at the capture edge, which separates a correct snapshot from a live read or an off-by-one-cycle copy. A second sweep after further random traffic, with no new capture, tells a frozen bank from one that tracks the live counters. Directed cases issue commands during busy, name invalid ports and opcodes, fetch indexes past the end and write the data registers. Each of these shows whether a stray write leaks into state.

// File: rtl/snap_pkg.sv
package snap_pkg;

    localparam int WORD_W = 32;

    localparam logic [4:0] REG_CMD = 5'h1D;
    localparam logic [4:0] REG_HI  = 5'h1E;
    localparam logic [4:0] REG_LO  = 5'h1F;

    typedef enum logic [5:0] {
        OP_CAPTURE = 6'b110111,
        OP_FETCH   = 6'b110011
    } snap_op_e;

endpackage

// File: rtl/snap_cmd_ctrl.sv
module snap_cmd_ctrl
    import snap_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [4:0]  waddr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        cap_go,
    output logic        fetch_go,
    output logic [9:0]  arg
);

    localparam int         CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [9:0] PORT_LIM = 10'(NUM_PORTS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     idle;
    logic     hit;

    always_comb begin
        st_d     = st_q;
        arg      = wdata[9:0];
        idle     = (st_q.cnt == '0);
        hit      = we && (waddr == REG_CMD);
        cap_go   = hit && idle && (wdata[15:10] == OP_CAPTURE) && (wdata[9:0] < PORT_LIM);
        fetch_go = hit && idle && (wdata[15:10] == OP_FETCH);
        if (cap_go || fetch_go) begin
            st_d.cnt = CNT_W'(BUSY_CYCLES);
        end else if (!idle) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    AST_GO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_go && fetch_go)); // R5

endmodule

// File: rtl/snap_counter_bank.sv
module snap_counter_bank
    import snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_EVT   = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_PORTS-1:0][NUM_EVT-1:0]             evt_inc,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]              oct_add,
    output logic [NUM_PORTS-1:0][NUM_EVT-1:0][WORD_W-1:0] evt_cnt,
    output logic [NUM_PORTS-1:0][2*WORD_W-1:0]            oct_cnt
);

    typedef struct packed {
        logic [NUM_EVT-1:0][WORD_W-1:0] evt;
        logic [2*WORD_W-1:0]            oct;
    } port_st_t;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        port_st_t pst_d, pst_q;

        always_comb begin
            pst_d = pst_q;
            for (int e = 0; e < NUM_EVT; e++) begin
                pst_d.evt[e] = pst_q.evt[e] + WORD_W'(evt_inc[g][e]);
            end
            pst_d.oct = pst_q.oct + {{WORD_W{1'b0}}, oct_add[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pst_q <= '0;
            end else begin
                pst_q <= pst_d;
            end
        end

        assign evt_cnt[g] = pst_q.evt;
        assign oct_cnt[g] = pst_q.oct;
    end

endmodule

// File: rtl/snap_capture_bank.sv
module snap_capture_bank
    import snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_EVT   = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cap_go,
    input  logic                                          fetch_go,
    input  logic [9:0]                                    arg,
    input  logic [NUM_PORTS-1:0][NUM_EVT-1:0][WORD_W-1:0] evt_cnt,
    input  logic [NUM_PORTS-1:0][2*WORD_W-1:0]            oct_cnt,
    output logic [WORD_W-1:0]                             word
);

    localparam int         PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int         EV_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [9:0] IDX_LO = 10'(NUM_EVT);
    localparam logic [9:0] IDX_HI = 10'(NUM_EVT + 1);

    typedef struct packed {
        logic [NUM_EVT-1:0][WORD_W-1:0] evt;
        logic [2*WORD_W-1:0]            oct;
        logic [WORD_W-1:0]              word;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_go) begin
            st_d.evt = evt_cnt[arg[PORT_W-1:0]];
            st_d.oct = oct_cnt[arg[PORT_W-1:0]];
        end
        if (fetch_go) begin
            if (arg < IDX_LO) begin
                st_d.word = st_q.evt[arg[EV_W-1:0]];
            end else if (arg == IDX_LO) begin
                st_d.word = st_q.oct[WORD_W-1:0];
            end else if (arg == IDX_HI) begin
                st_d.word = st_q.oct[2*WORD_W-1:WORD_W];
            end else begin
                st_d.word = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

    AST_FAR_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && (arg > IDX_HI)) |=> (word == '0)); // R9

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_go |=> ($stable(st_q.evt) && $stable(st_q.oct))); // R6

endmodule

// File: rtl/port_stats_snap.sv
module port_stats_snap
    import snap_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_EVT     = 4,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*NUM_EVT-1:0]  evt_inc,
    input  logic [NUM_PORTS*WORD_W-1:0]   oct_add,
    input  logic                          reg_we,
    input  logic [4:0]                    reg_waddr,
    input  logic [15:0]                   reg_wdata,
    input  logic [4:0]                    reg_raddr,
    output logic [15:0]                   reg_rdata
);

    localparam logic [9:0] PORT_LIM = 10'(NUM_PORTS);

    logic [NUM_PORTS-1:0][NUM_EVT-1:0]             inc_arr;
    logic [NUM_PORTS-1:0][WORD_W-1:0]              add_arr;
    logic [NUM_PORTS-1:0][NUM_EVT-1:0][WORD_W-1:0] evt_cnt;
    logic [NUM_PORTS-1:0][2*WORD_W-1:0]            oct_cnt;
    logic                                          busy;
    logic                                          cap_go;
    logic                                          fetch_go;
    logic [9:0]                                    arg;
    logic [WORD_W-1:0]                             word;

    assign inc_arr = evt_inc;
    assign add_arr = oct_add;

    snap_cmd_ctrl #(
        .NUM_PORTS   (NUM_PORTS),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .cap_go   (cap_go),
        .fetch_go (fetch_go),
        .arg      (arg)
    );

    snap_counter_bank #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_EVT   (NUM_EVT)
    ) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_inc (inc_arr),
        .oct_add (add_arr),
        .evt_cnt (evt_cnt),
        .oct_cnt (oct_cnt)
    );

    snap_capture_bank #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_EVT   (NUM_EVT)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_go   (cap_go),
        .fetch_go (fetch_go),
        .arg      (arg),
        .evt_cnt  (evt_cnt),
        .oct_cnt  (oct_cnt),
        .word     (word)
    );

    always_comb begin
        case (reg_raddr)
            REG_CMD: reg_rdata = {busy, 15'b0};
            REG_HI:  reg_rdata = word[31:16];
            REG_LO:  reg_rdata = word[15:0];
            default: reg_rdata = '0;
        endcase
    end

    AST_BUSY_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == REG_CMD && reg_wdata[15:10] == OP_FETCH && !busy) |=> busy); // R7

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word)); // R8

    AST_BAD_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == REG_CMD && reg_wdata[15:10] == OP_CAPTURE &&
         reg_wdata[9:0] >= PORT_LIM && !busy) |=> !busy); // R10

endmodule

// File: tb/port_stats_snap_tb.sv
module port_stats_snap_tb;

    localparam int NP = 4;
    localparam int NE = 4;
    localparam int BC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NE-1:0]  evt_inc = '0;
    logic [NP*32-1:0]  oct_add = '0;
    logic              reg_we = 1'b0;
    logic [4:0]        reg_waddr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [4:0]        reg_raddr = 5'h1D;
    logic [15:0]       reg_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_evt [NP][NE];
    logic [63:0] m_oct [NP];
    logic [31:0] s_evt [NE];
    logic [63:0] s_oct;
    logic [31:0] m_word;
    int          m_busy;
    bit          rand_en;
    logic [NP*NE-1:0] nxt_inc;
    logic [NP*32-1:0] nxt_add;

    always #10 clk = ~clk;

    port_stats_snap #(.NUM_PORTS(NP), .NUM_EVT(NE), .BUSY_CYCLES(BC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_inc   (evt_inc),
        .oct_add   (oct_add),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int idx);
        if (idx < NE) return s_evt[idx];
        if (idx == NE) return s_oct[31:0];
        if (idx == NE + 1) return s_oct[63:32];
        return 32'h0;
    endfunction

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step(input logic we, input logic [4:0] a, input logic [15:0] d);
        int arg;
        bit acc;
        reg_we = we;
        reg_waddr = a;
        reg_wdata = d;
        if (rand_en) begin
            nxt_inc = NP*NE'($urandom);
            for (int p = 0; p < NP; p++) begin
                nxt_add[p*32 +: 32] = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : 32'($urandom_range(0, 1518));
            end
        end
        evt_inc = nxt_inc;
        oct_add = nxt_add;
        @(posedge clk);
        arg = int'(d[9:0]);
        acc = 1'b0;
        if (we && a == 5'h1D && m_busy == 0) begin
            if (d[15:10] == 6'b110111 && arg < NP) begin
                for (int e = 0; e < NE; e++) s_evt[e] = m_evt[arg][e];
                s_oct = m_oct[arg];
                acc = 1'b1;
            end else if (d[15:10] == 6'b110011) begin
                m_word = exp_word(arg);
                acc = 1'b1;
            end
        end
        if (acc) m_busy = BC;
        else if (m_busy > 0) m_busy--;
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) m_evt[p][e] += 32'(nxt_inc[p*NE+e]);
            m_oct[p] += {32'h0, nxt_add[p*32 +: 32]};
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 10; i++) begin
            rd(5'h1D, v);
            check("R7 busy tracks command", 64'(v[15]), 64'(m_busy != 0));
            if (!v[15]) break;
            step(1'b0, 5'h0, 16'h0);
        end
        rd(5'h1D, v);
        check("R7 busy clears within poll limit", 64'(v), 64'h0);
    endtask

    task automatic fetch(input int idx, input string tag);
        logic [15:0] hi, lo, v;
        step(1'b1, 5'h1D, 16'hCC00 | 16'(idx));
        rd(5'h1D, v);
        check("R7 busy set after fetch", 64'(v[15]), 64'h1);
        wait_idle();
        rd(5'h1E, hi);
        rd(5'h1F, lo);
        check(tag, {32'h0, hi, lo}, {32'h0, exp_word(idx)});
    endtask

    task automatic capture(input int p);
        step(1'b1, 5'h1D, 16'hDC00 | 16'(p));
        wait_idle();
    endtask

    function automatic string idx_tag(input int idx);
        if (idx < NE) return "R2 R4 event word";
        if (idx <= NE + 1) return "R3 R4 byte word";
        return "R9 far index";
    endfunction

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, hi, lo;
        logic [31:0] keep;
        void'($urandom(32'd2718));
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < NE; e++) m_evt[p][e] = '0;
            m_oct[p] = '0;
        end
        for (int e = 0; e < NE; e++) s_evt[e] = '0;
        s_oct = '0;
        m_word = '0;
        m_busy = 0;
        rand_en = 1'b0;
        nxt_inc = '0;
        nxt_add = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(5'h1D, v); check("R1 reset command reg", 64'(v), 64'h0);
        rd(5'h1E, v); check("R1 reset upper data", 64'(v), 64'h0);
        rd(5'h1F, v); check("R1 reset lower data", 64'(v), 64'h0);

        rand_en = 1'b1;
        for (int round = 0; round < 24; round++) begin
            int p;
            p = $urandom_range(0, NP - 1);
            repeat ($urandom_range(1, 40)) step(1'b0, 5'h0, 16'h0);
            capture(p);
            for (int idx = 0; idx < NE + 3; idx++) fetch(idx, idx_tag(idx));
            repeat ($urandom_range(5, 30)) step(1'b0, 5'h0, 16'h0);
            for (int idx = 0; idx < NE + 2; idx++) fetch(idx, "R6 frozen after live traffic");
        end

        // R3: carry into the high word of the byte counter
        rand_en = 1'b0;
        nxt_inc = '0;
        nxt_add = '0;
        nxt_add[63:32] = 32'hFFFF_FFFF;
        step(1'b0, 5'h0, 16'h0);
        step(1'b0, 5'h0, 16'h0);
        step(1'b0, 5'h0, 16'h0);
        nxt_add = '0;
        capture(1);
        fetch(NE + 1, "R3 high word after carry");
        fetch(NE, "R3 low word after carry");

        // R5: split of the word across the two data registers
        fetch(NE + 1, "R5 fetch");
        rd(5'h1E, hi);
        rd(5'h1F, lo);
        check("R5 upper half at 0x1E", 64'(hi), 64'(m_word[31:16]));
        check("R5 lower half at 0x1F", 64'(lo), 64'(m_word[15:0]));

        // R8: commands during busy are dropped
        rand_en = 1'b1;
        keep = m_word;
        step(1'b1, 5'h1D, 16'hDC00 | 16'd2);
        step(1'b1, 5'h1D, 16'hCC00 | 16'd0);
        step(1'b1, 5'h1D, 16'hDC00 | 16'd3);
        wait_idle();
        rd(5'h1E, hi);
        rd(5'h1F, lo);
        check("R8 data kept during busy", {32'h0, hi, lo}, {32'h0, keep});
        for (int idx = 0; idx < NE + 2; idx++) fetch(idx, "R8 bank holds first capture");

        // R10: invalid port and unknown opcode
        rand_en = 1'b0;
        nxt_inc = '0;
        nxt_add = '0;
        step(1'b1, 5'h1D, 16'hDC00 | 16'd7);
        rd(5'h1D, v);
        check("R10 bad port leaves busy clear", 64'(v), 64'h0);
        step(1'b1, 5'h1D, 16'h1234);
        rd(5'h1D, v);
        check("R10 unknown opcode leaves busy clear", 64'(v), 64'h0);
        fetch(0, "R10 bank unchanged by bad port");

        // R11: data registers are read-only; other addresses read zero
        keep = m_word;
        step(1'b1, 5'h1E, 16'hBEEF);
        step(1'b1, 5'h1F, 16'h1357);
        rd(5'h1E, hi);
        rd(5'h1F, lo);
        check("R11 data regs ignore writes", {32'h0, hi, lo}, {32'h0, keep});
        rd(5'h05, v);
        check("R11 unused address reads zero", 64'(v), 64'h0);

        // R9: far index
        fetch(NE + 2, "R9 index past end");
        fetch(1023, "R9 largest index");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule